// File: doc/BRIEF.md
# Printer Port Host Register File

This block is the host-facing register set of a classic byte-wide printer port. A small synchronous register bus (two-bit offset, separate write and read strobes, eight-bit data) reaches three registers. One latch drives the eight data lines, one read-only view reports five printer status lines, and one latch drives four open-collector handshake lines plus two internal bits. The internal bits are an interrupt enable and a data-bus output disable.

Every pin input goes through a two-flop synchronizer before it reaches the read path or the edge detector. Reads of the data and control registers return what is actually on the lines, not what was written. This lets software see external drivers: a tristated data bus becomes an input port, and a released handshake line can be pulled low from outside. A rising edge on the acknowledge line, when enabled, latches an interrupt level. That level stays high until software reads the status register.

Top module: `pport_regif`

## Requirements
- R1: After reset, `data_out` is 0x00, `data_oe` is 1, `ctrl_pull_low` is 4'b1000 (only the select line pulled low, since the control latch resets to 0x0C), and `irq` is 0.
- R2: A write to offset 0 drives `bus_wdata` onto `data_out` without inversion, visible the cycle after the write strobe.
- R3: A read of offset 0 returns `data_in`, the level on the data pads, after a two-flop synchronizer.
- R4: A read of offset 1 returns {~busy, ack_n, paper_out, selected, fault_n, 3'b111}, with bit 7 the inverse of the busy line and bits 6..3 the line levels as seen.
- R5: A write to offset 2 sets `ctrl_pull_low` to wdata[3:0] XOR 4'b0100. Bits 0 (strobe), 1 (autofeed) and 3 (select) give a low line when set. Bit 2 (init) gives a high line when set.
- R6: A read of offset 2 returns {2'b11, stored bit 5, stored bit 4, observed line levels XOR 4'b1011}.
- R7: When a control bit leaves its line released, an external low on that line shows in the offset 2 readback as the bit's asserted-low value.
- R8: Control bit 5 set to 1 drives `data_oe` to 0. While it is set, an offset 0 read returns the externally driven data and not the latch.
- R9: A rising edge of the synchronized acknowledge line sets `irq` only while control bit 4 is 1. An edge seen while the bit is 0 is dropped.
- R10: `irq` is a level that holds until a read of offset 1 clears it. If a new enabled edge arrives in the same cycle as that read, `irq` stays set.
- R11: Writes to offsets 1 and 3 change no output. A read of offset 3 returns 0xFF.
- R12: `bus_rdata` is registered. It updates on the clock edge that samples `bus_rd` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| data_out | output | 8 | Data line drive value |
| data_oe | output | 1 | Data line output enable (1 = drive) |
| data_in | input | 8 | Data pad level as observed |
| ctrl_pull_low | output | 4 | Open-collector handshake drivers, 1 = pull low; bit 0 strobe, 1 autofeed, 2 init, 3 select |
| ctrl_line_in | input | 4 | Observed handshake line levels |
| st_busy | input | 1 | Busy line level |
| st_ack_n | input | 1 | Acknowledge line level (active low) |
| st_paper_out | input | 1 | Paper-out line level |
| st_selected | input | 1 | Printer-selected line level |
| st_fault_n | input | 1 | Fault line level (active low) |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach is a status read that falls in the same cycle as a fresh enabled acknowledge edge. The edge appears three clock edges after the pin moves, and the set must win over the clear. The stimulus first leaves an interrupt pending. It then raises the acknowledge pin on a known falling clock edge, counts two more falling edges through the synchronizer, and lands the status read on the edge where the detector fires. It then checks that `irq` is still high and that a second read clears it. The open-collector and tristate readback cases are reached with a pad model in the bench that resolves external drivers against the block's drive outputs.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam int REG_W  = 8;
  localparam int CTRL_W = 4;
  localparam int STAT_W = 5;

  typedef enum logic [1:0] {
    OFS_DATA  = 2'd0,
    OFS_STAT  = 2'd1,
    OFS_CTRL  = 2'd2,
    OFS_SPARE = 2'd3
  } reg_ofs_e;

  // handshake bits whose line level is the inverse of the register bit
  localparam logic [CTRL_W-1:0] CTRL_INV   = 4'b1011;
  localparam logic [REG_W-1:0]  CTRL_RESET = 8'h0C;
  localparam int CTRL_STORE_W = 6;

  // register bits -> line level that the bit requests
  function automatic logic [CTRL_W-1:0] ctrl_level(input logic [CTRL_W-1:0] bits);
    return bits ^ CTRL_INV;
  endfunction

  // open-collector: pull low wherever the requested level is low
  function automatic logic [CTRL_W-1:0] ctrl_pull(input logic [CTRL_W-1:0] bits);
    return ~ctrl_level(bits);
  endfunction

  // observed line level -> register view
  function automatic logic [CTRL_W-1:0] ctrl_view(input logic [CTRL_W-1:0] line);
    return line ^ CTRL_INV;
  endfunction

  // status lines ordered {busy, ack_n, paper, selected, fault_n}
  function automatic logic [REG_W-1:0] status_view(input logic [STAT_W-1:0] lines);
    return {~lines[4], lines[3:0], 3'b111};
  endfunction

  function automatic logic [REG_W-1:0] ctrl_readback(input logic [CTRL_STORE_W-1:0] stored,
                                                     input logic [CTRL_W-1:0] line);
    return {2'b11, stored[5:4], ctrl_view(line)};
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pport_latch.sv
module pport_latch
  import pport_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [1:0]              addr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        data_q,
  output logic [CTRL_STORE_W-1:0] ctrl_q,
  output logic                    hit_data,
  output logic                    hit_ctrl
);
  assign hit_data = wr && (reg_ofs_e'(addr) == OFS_DATA);
  assign hit_ctrl = wr && (reg_ofs_e'(addr) == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= CTRL_RESET[CTRL_STORE_W-1:0];
    end else begin
      if (hit_data) data_q <= wdata;
      if (hit_ctrl) ctrl_q <= wdata[CTRL_STORE_W-1:0];
    end
  end
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_lvl,
  input  logic enable,
  input  logic clear,
  output logic irq,
  output logic ack_rise,
  output logic irq_set
);
  logic ack_prev;

  assign ack_rise = ack_lvl && !ack_prev;
  assign irq_set  = ack_rise && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ack_prev <= ack_lvl;
      if (irq_set)    irq <= 1'b1;
      else if (clear) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
  import pport_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd,
  input  logic [1:0]              addr,
  input  logic [REG_W-1:0]        data_s,
  input  logic [CTRL_W-1:0]       line_s,
  input  logic [STAT_W-1:0]       stat_s,
  input  logic [CTRL_STORE_W-1:0] ctrl_q,
  output logic [REG_W-1:0]        rdata,
  output logic                    stat_read
);
  logic [REG_W-1:0] sel;

  assign stat_read = rd && (reg_ofs_e'(addr) == OFS_STAT);

  always_comb begin
    unique case (reg_ofs_e'(addr))
      OFS_DATA: sel = data_s;
      OFS_STAT: sel = status_view(stat_s);
      OFS_CTRL: sel = ctrl_readback(ctrl_q, line_s);
      default:  sel = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/pport_regif.sv
module pport_regif
  import pport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  data_out,
  output logic              data_oe,
  input  logic [REG_W-1:0]  data_in,
  output logic [CTRL_W-1:0] ctrl_pull_low,
  input  logic [CTRL_W-1:0] ctrl_line_in,
  input  logic              st_busy,
  input  logic              st_ack_n,
  input  logic              st_paper_out,
  input  logic              st_selected,
  input  logic              st_fault_n,
  output logic              irq
);
  localparam int PIN_W = REG_W + CTRL_W + STAT_W;

  logic [CTRL_STORE_W-1:0] ctrl_q;
  logic [PIN_W-1:0]        pins_raw, pins_s;
  logic [REG_W-1:0]        data_s;
  logic [CTRL_W-1:0]       line_s;
  logic [STAT_W-1:0]       stat_s;
  logic                    hit_data, hit_ctrl, stat_read, ack_rise, irq_set;

  assign pins_raw = {data_in, ctrl_line_in,
                     st_busy, st_ack_n, st_paper_out, st_selected, st_fault_n};

  pport_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  assign data_s = pins_s[PIN_W-1 -: REG_W];
  assign line_s = pins_s[STAT_W +: CTRL_W];
  assign stat_s = pins_s[STAT_W-1:0];

  pport_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .data_q(data_out), .ctrl_q(ctrl_q), .hit_data(hit_data), .hit_ctrl(hit_ctrl)
  );

  assign ctrl_pull_low = ctrl_pull(ctrl_q[CTRL_W-1:0]);
  assign data_oe       = !ctrl_q[5];

  pport_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .data_s(data_s), .line_s(line_s), .stat_s(stat_s), .ctrl_q(ctrl_q),
    .rdata(bus_rdata), .stat_read(stat_read)
  );

  // status bit order {busy, ack_n, ...}: ack_n is index 3
  pport_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ack_lvl(stat_s[3]), .enable(ctrl_q[4]),
    .clear(stat_read), .irq(irq), .ack_rise(ack_rise), .irq_set(irq_set)
  );
endmodule

// File: rtl/pport_regif_chk.sv
module pport_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic [3:0] ctrl_pull_low,
  input logic       irq,
  input logic       ack_rise,
  input logic       irq_set,
  input logic       ien
);
  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> data_out == $past(bus_wdata));

  assert_status_low_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |=> bus_rdata[2:0] == 3'b111);

  assert_ctrl_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> ctrl_pull_low == ($past(bus_wdata[3:0]) ^ 4'b0100));

  assert_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> data_oe == !$past(bus_wdata[5]));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_rise && ien));

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1 && !irq_set) |=> !irq);

  assert_irq_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);

  assert_dead_offsets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0]) |=> $stable(data_out) && $stable(ctrl_pull_low) && $stable(data_oe));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind pport_regif pport_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_out(data_out), .data_oe(data_oe),
  .ctrl_pull_low(ctrl_pull_low), .irq(irq), .ack_rise(ack_rise), .irq_set(irq_set),
  .ien(ctrl_q[4])
);

// File: tb/tb_pport_regif.sv
module tb_pport_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, data_out, data_in, ext_data = '0;
  logic       data_oe, irq;
  logic [3:0] ctrl_pull_low, ctrl_line_in, ext_pull = '0;
  logic       st_busy = 0, st_ack_n = 1, st_paper_out = 0, st_selected = 0, st_fault_n = 1;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  // pad model: tristated bus floats to the external driver, OC lines wired-AND
  assign data_in      = data_oe ? data_out : ext_data;
  assign ctrl_line_in = ~ctrl_pull_low & ~ext_pull;

  pport_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_out(data_out), .data_oe(data_oe),
    .data_in(data_in), .ctrl_pull_low(ctrl_pull_low), .ctrl_line_in(ctrl_line_in),
    .st_busy(st_busy), .st_ack_n(st_ack_n), .st_paper_out(st_paper_out),
    .st_selected(st_selected), .st_fault_n(st_fault_n), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all driver tasks are entered just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare each read result away from the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("R12 unexpected read", 0, 1);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    check("R1 data_out", data_out, 8'h00);
    check("R1 data_oe", data_oe, 1);
    check("R1 pull_low", ctrl_pull_low, 4'b1000);
    check("R1 irq", irq, 0);
    rd(2'd2, 8'hCC, "R6 reset ctrl readback");
    rd(2'd0, 8'h00, "R3 reset data readback");
    check("R12 rdata hold", bus_rdata, 8'h00);

    // R2 / R3 data path
    wr(2'd0, 8'hA5);
    check("R2 data_out", data_out, 8'hA5);
    idle(3);
    rd(2'd0, 8'hA5, "R3 data readback");
    wr(2'd0, 8'h3C);
    check("R2 data_out", data_out, 8'h3C);
    idle(3);
    rd(2'd0, 8'h3C, "R3 data readback");
    idle(2);
    check("R12 rdata holds", bus_rdata, 8'h3C);

    // R4 status layout
    st_busy = 1; st_ack_n = 1; st_paper_out = 0; st_selected = 1; st_fault_n = 0;
    idle(3);
    rd(2'd1, 8'h57, "R4 status pattern A");
    st_busy = 0; st_ack_n = 0; st_paper_out = 1; st_selected = 0; st_fault_n = 1;
    idle(3);
    rd(2'd1, 8'hAF, "R4 status pattern B");

    // R5 / R6 control drive and readback
    wr(2'd2, 8'h05);
    check("R5 pull_low 05", ctrl_pull_low, 4'b0001);
    idle(3);
    rd(2'd2, 8'hC5, "R6 ctrl readback 05");
    wr(2'd2, 8'h0A);
    check("R5 pull_low 0A", ctrl_pull_low, 4'b1110);
    idle(3);
    rd(2'd2, 8'hCA, "R6 ctrl readback 0A");

    // R7 external pull on released lines
    wr(2'd2, 8'h04);
    check("R7 all released", ctrl_pull_low, 4'b0000);
    idle(3);
    rd(2'd2, 8'hC4, "R7 released readback");
    ext_pull = 4'b0110;
    idle(3);
    rd(2'd2, 8'hC2, "R7 external pull readback");
    ext_pull = 4'b0000;

    // R8 tristate data bus
    ext_data = 8'h5A;
    wr(2'd2, 8'h24);
    check("R8 data_oe off", data_oe, 0);
    idle(3);
    rd(2'd0, 8'h5A, "R8 external data readback");
    rd(2'd2, 8'hE4, "R6 bit5 readback");
    wr(2'd2, 8'h04);
    check("R8 data_oe on", data_oe, 1);
    idle(3);
    rd(2'd0, 8'h3C, "R8 latch readback again");

    // R11 dead offsets
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'hFF);
    check("R11 data_out unchanged", data_out, 8'h3C);
    check("R11 pull_low unchanged", ctrl_pull_low, 4'b0000);
    check("R11 data_oe unchanged", data_oe, 1);
    rd(2'd3, 8'hFF, "R11 spare offset read");

    // R9 edge while disabled is dropped
    st_ack_n = 0; idle(4);
    st_ack_n = 1; idle(5);
    check("R9 disabled edge", irq, 0);
    wr(2'd2, 8'h14);
    st_ack_n = 0; idle(4);
    check("R9 falling edge no irq", irq, 0);
    st_ack_n = 1; idle(5);
    check("R9 enabled edge", irq, 1);

    // R10 level holds, status read clears
    idle(10);
    check("R10 irq holds", irq, 1);
    rd(2'd1, 8'hEF, "R10 clearing status read");
    check("R10 irq cleared", irq, 0);

    // R10 collision: new edge on the clearing read's edge
    st_ack_n = 0; idle(4);
    st_ack_n = 1; idle(5);
    check("R10 pending before collision", irq, 1);
    st_ack_n = 0; idle(4);
    st_ack_n = 1;
    idle(2);
    rd(2'd1, 8'hEF, "R10 collision status read");
    check("R10 set wins over clear", irq, 1);
    rd(2'd1, 8'hEF, "R10 follow-up read");
    check("R10 cleared after follow-up", irq, 0);

    idle(4);
    check("R12 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule